// File: doc/BRIEF.md
# Dual-Channel Match Timer with Snapshot 64-bit Counter

This peripheral gives each of two processor cores a private one-shot event timer and gives the whole system one shared, wide, free-running time base. Each event channel is a 32-bit up-counter with its own prescaler. Software arms an event by clearing the channel count, writing a match value and then switching the channel on. When the count reaches the match value, the channel's sticky status bit is set, and its interrupt line rises while the channel stays enabled.

The 64-bit time base sits idle after reset until software issues its first load command. From then on it runs freely at its own prescaled rate. Software cannot read it safely as two separate halves, so it issues a snapshot command. That command copies all 64 bits into a shadow pair in a single clock edge, and software then reads the pair at leisure. All access goes through a simple 32-bit register bus with single-cycle writes and combinational reads.

Top module: `tmr_dual_match`

## Requirements
- R1: After reset, every register reads 0, both interrupt lines are low, and the 64-bit counter does not advance.
- R2: A channel counts only while its control bits [2:0] equal 3'b111. Any other value holds the count. While counting, the count rises by one every (P+1) clocks, where P is control bits [31:16]. The first increment comes P+1 clocks after the enabling write.
- R3: Register offsets are fixed. Channel n has its control at 0x00+4n, its match at 0x18+4n and its count at 0x48+4n. Status is at 0x60 and the watchdog-enable storage word is at 0x64. The wide counter has its control at 0x68, live low and high at 0x6C and 0x70, load low and high at 0x74 and 0x78, and snapshot low and high at 0x7C and 0x80. A write to a count, match, load or watchdog register reads back unchanged.
- R4: When a channel's count steps onto its match value, status bit n is set. The bit stays set until cleared, and the channel keeps counting past the match.
- R5: irq[n] is high exactly when status bit n is set and channel n is enabled. Disabling the channel drops irq[n] but keeps the status bit.
- R6: Writing the status register clears each bit written as 1 and leaves the other bits alone. Writing 0xFFFF clears everything.
- R7: Writing the wide control with bits [1:0]=2'b11 loads the live 64-bit counter from the load pair and starts it running.
- R8: Writing the wide control with bits [1:0]=2'b01 copies the live 64-bit value, as it stood before that edge, into the snapshot pair as one coherent value, even across a carry from the low word into the high word.
- R9: The wide counter advances once every (Q+1) clocks, where Q is wide-control bits [31:16], written with the same command write.
- R10: Wide-control bits [1:0] act as one-shot commands and always read as 0. Bits [31:16] read back the prescale value.
- R11: The live 64-bit counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr when selected |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
The checker runs on every cycle. It confirms that no interrupt is raised without its status bit, that status bits survive any cycle without a clearing write, and that channel counts move by at most one step unless software writes them. It also confirms that the idle wide counter holds still, that a snapshot equals the live value of the cycle before, and that the command bits always read as zero. Exact prescaled timing needs the bench's scenarios to show it. The same goes for the match edge cycle, survival across the low-to-high carry, wrap-around and selective clearing of status, all of which the bench drives with random prescale and match values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH = 2;
    localparam int CW  = 32;
    localparam int PW  = 16;
    localparam int PSH = 16;
    localparam int WW  = 64;
    localparam int AW  = 8;

    localparam logic [AW-1:0] A_CTRL_BASE  = 8'h00;
    localparam logic [AW-1:0] A_MATCH_BASE = 8'h18;
    localparam logic [AW-1:0] A_CNT_BASE   = 8'h48;
    localparam logic [AW-1:0] A_STAT       = 8'h60;
    localparam logic [AW-1:0] A_WDOG       = 8'h64;
    localparam logic [AW-1:0] A_WCTRL      = 8'h68;
    localparam logic [AW-1:0] A_LIVE_LO    = 8'h6C;
    localparam logic [AW-1:0] A_LIVE_HI    = 8'h70;
    localparam logic [AW-1:0] A_LOAD_LO    = 8'h74;
    localparam logic [AW-1:0] A_LOAD_HI    = 8'h78;
    localparam logic [AW-1:0] A_SNAP_LO    = 8'h7C;
    localparam logic [AW-1:0] A_SNAP_HI    = 8'h80;

    typedef enum logic [1:0] {
        WCMD_NONE = 2'b00,
        WCMD_SNAP = 2'b01,
        WCMD_RSVD = 2'b10,
        WCMD_LOAD = 2'b11
    } wcmd_e;

    typedef struct packed {
        logic [PW-1:0] presc;
        logic [2:0]    en;
    } chan_cfg_t;

    function automatic logic cfg_active(chan_cfg_t c);
        return c.en == 3'b111;
    endfunction

    function automatic logic [31:0] pack_ctrl(logic [PW-1:0] p, logic [2:0] en);
        return (32'(p) << PSH) | 32'(en);
    endfunction

    function automatic logic [AW-1:0] reg_at(logic [AW-1:0] base, int idx);
        return base + AW'(4 * idx);
    endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  chan_cfg_t     cfg_wd,
    input  logic          cnt_we,
    input  logic          match_we,
    input  logic [CW-1:0] wd,
    output chan_cfg_t     cfg_q,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] match_q,
    output logic          active,
    output logic          hit
);
    logic [PW-1:0] pre_q;
    logic          tick;

    assign active = cfg_active(cfg_q);
    assign tick   = active && (pre_q == cfg_q.presc);
    assign hit    = tick && !cnt_we && ((cnt_q + CW'(1)) == match_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            match_q <= '0;
            pre_q   <= '0;
        end else begin
            if (cfg_we)   cfg_q   <= cfg_wd;
            if (match_we) match_q <= wd;
            if (cnt_we) begin
                cnt_q <= wd;
                pre_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + CW'(1);
                pre_q <= '0;
            end else if (active) begin
                pre_q <= pre_q + PW'(1);
            end else begin
                pre_q <= '0;
            end
        end
    end
endmodule

// File: rtl/tmr_wide.sv
module tmr_wide
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  wcmd_e         cmd,
    input  logic [PW-1:0] presc_wd,
    input  logic          ldlo_we,
    input  logic          ldhi_we,
    input  logic [31:0]   wd,
    output logic [PW-1:0] presc_q,
    output logic [WW-1:0] live_q,
    output logic [WW-1:0] load_q,
    output logic [WW-1:0] snap_q,
    output logic          run_q
);
    logic [PW-1:0] pre_q;
    logic          do_load;
    logic          do_snap;
    logic          tick;

    assign do_load = ctrl_we && (cmd == WCMD_LOAD);
    assign do_snap = ctrl_we && (cmd == WCMD_SNAP);
    assign tick    = run_q && (pre_q == presc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            live_q  <= '0;
            load_q  <= '0;
            snap_q  <= '0;
            run_q   <= 1'b0;
            pre_q   <= '0;
        end else begin
            if (ctrl_we) presc_q <= presc_wd;
            if (ldlo_we) load_q[31:0]     <= wd;
            if (ldhi_we) load_q[WW-1:32]  <= wd;
            if (do_snap) snap_q <= live_q;
            if (do_load) begin
                live_q <= load_q;
                pre_q  <= '0;
                run_q  <= 1'b1;
            end else if (tick) begin
                live_q <= live_q + WW'(1);
                pre_q  <= '0;
            end else if (run_q) begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/tmr_dual_match.sv
module tmr_dual_match
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic [1:0]    irq
);
    logic               wr;
    chan_cfg_t          ch_cfg   [NCH];
    logic [CW-1:0]      ch_cnt   [NCH];
    logic [CW-1:0]      ch_match [NCH];
    logic [NCH-1:0]     ch_act;
    logic [NCH-1:0]     ch_hit;
    logic [NCH-1:0]     stat_q;
    logic [31:0]        wdog_q;
    logic [PW-1:0]      w_presc;
    logic [WW-1:0]      w_live;
    logic [WW-1:0]      w_load;
    logic [WW-1:0]      w_snap;
    logic               w_run;
    chan_cfg_t          cfg_wd;

    assign wr     = bus_sel && bus_wr;
    assign cfg_wd = '{presc: bus_wdata[PSH +: PW], en: bus_wdata[2:0]};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (wr && bus_addr == reg_at(A_CTRL_BASE, i)),
            .cfg_wd   (cfg_wd),
            .cnt_we   (wr && bus_addr == reg_at(A_CNT_BASE, i)),
            .match_we (wr && bus_addr == reg_at(A_MATCH_BASE, i)),
            .wd       (bus_wdata),
            .cfg_q    (ch_cfg[i]),
            .cnt_q    (ch_cnt[i]),
            .match_q  (ch_match[i]),
            .active   (ch_act[i]),
            .hit      (ch_hit[i])
        );
    end

    tmr_wide u_wide (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (wr && bus_addr == A_WCTRL),
        .cmd      (wcmd_e'(bus_wdata[1:0])),
        .presc_wd (bus_wdata[PSH +: PW]),
        .ldlo_we  (wr && bus_addr == A_LOAD_LO),
        .ldhi_we  (wr && bus_addr == A_LOAD_HI),
        .wd       (bus_wdata),
        .presc_q  (w_presc),
        .live_q   (w_live),
        .load_q   (w_load),
        .snap_q   (w_snap),
        .run_q    (w_run)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            wdog_q <= '0;
        end else begin
            if (wr && bus_addr == A_WDOG) wdog_q <= bus_wdata;
            if (wr && bus_addr == A_STAT)
                stat_q <= (stat_q & ~bus_wdata[NCH-1:0]) | ch_hit;
            else
                stat_q <= stat_q | ch_hit;
        end
    end

    assign irq = stat_q & ch_act;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == reg_at(A_CTRL_BASE, i))
                    bus_rdata = pack_ctrl(ch_cfg[i].presc, ch_cfg[i].en);
                if (bus_addr == reg_at(A_MATCH_BASE, i)) bus_rdata = ch_match[i];
                if (bus_addr == reg_at(A_CNT_BASE, i))   bus_rdata = ch_cnt[i];
            end
            case (bus_addr)
                A_STAT:    bus_rdata = 32'(stat_q);
                A_WDOG:    bus_rdata = wdog_q;
                A_WCTRL:   bus_rdata = pack_ctrl(w_presc, 3'b000);
                A_LIVE_LO: bus_rdata = w_live[31:0];
                A_LIVE_HI: bus_rdata = w_live[WW-1:32];
                A_LOAD_LO: bus_rdata = w_load[31:0];
                A_LOAD_HI: bus_rdata = w_load[WW-1:32];
                A_SNAP_LO: bus_rdata = w_snap[31:0];
                A_SNAP_HI: bus_rdata = w_snap[WW-1:32];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_dual_match_chk.sv
module tmr_dual_match_chk
    import tmr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic [1:0]    irq,
    input logic [1:0]    stat,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1,
    input logic [WW-1:0] live,
    input logic [WW-1:0] snap,
    input logic          run
);
    logic wr, clr0, clr1, wcnt0, wcnt1, load_cmd, snap_cmd;
    assign wr       = bus_sel && bus_wr;
    assign clr0     = wr && bus_addr == A_STAT && bus_wdata[0];
    assign clr1     = wr && bus_addr == A_STAT && bus_wdata[1];
    assign wcnt0    = wr && bus_addr == reg_at(A_CNT_BASE, 0);
    assign wcnt1    = wr && bus_addr == reg_at(A_CNT_BASE, 1);
    assign load_cmd = wr && bus_addr == A_WCTRL && bus_wdata[1:0] == 2'b11;
    assign snap_cmd = wr && bus_addr == A_WCTRL && bus_wdata[1:0] == 2'b01;

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (irq & ~stat) == 2'b00); // R5
    AST_STATUS0_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat[0] && !clr0) |=> stat[0]); // R4
    AST_STATUS1_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat[1] && !clr1) |=> stat[1]); // R4
    AST_CNT0_STEP: assert property (@(posedge clk) disable iff (rst)
        !wcnt0 |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 32'd1)); // R2
    AST_CNT1_STEP: assert property (@(posedge clk) disable iff (rst)
        !wcnt1 |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + 32'd1)); // R2
    AST_WIDE_HALTED: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_cmd) |=> $stable(live)); // R7
    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (rst)
        snap_cmd |=> snap == $past(live)); // R8
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == A_WCTRL) |-> bus_rdata[1:0] == 2'b00); // R10
endmodule

bind tmr_dual_match tmr_dual_match_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .stat      (stat_q),
    .cnt0      (ch_cnt[0]),
    .cnt1      (ch_cnt[1]),
    .live      (w_live),
    .snap      (w_snap),
    .run       (w_run)
);

// File: tb/tmr_dual_match_bench.sv
module tmr_dual_match_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_dual_match u_tmr_dual_match (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic longint unsigned ticks(int unsigned d, int unsigned p);
        return longint'(d / (p + 1));
    endfunction

    function automatic logic [31:0] ctrl_word(int unsigned p, logic [2:0] en);
        return (32'(p) << 16) | 32'(en);
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap_test(string req, logic [63:0] x, int unsigned p, int unsigned d);
        logic [31:0] lo, hi;
        wr(8'h74, x[31:0]);
        wr(8'h78, x[63:32]);
        wr(8'h68, ctrl_word(p, 3'b011));
        idle(d);
        wr(8'h68, ctrl_word(p, 3'b001));
        rd(8'h7C, lo);
        rd(8'h80, hi);
        chk(req, {hi, lo}, x + ticks(d, p));
    endtask

    task automatic arm_test(int ch, int unsigned p, int unsigned m, int unsigned extra);
        logic [31:0] v;
        logic [7:0] ca, ma, na;
        ca = 8'(4 * ch); ma = 8'h18 + 8'(4 * ch); na = 8'h48 + 8'(4 * ch);
        wr(8'h60, 32'hFFFF);
        wr(na, 32'd0);
        wr(ma, m);
        wr(ca, ctrl_word(p, 3'b111));
        idle(m * (p + 1) - 1);
        rd(8'h60, v);
        chk("R4 status before match", 64'(v[ch]), 64'd0);
        idle(1);
        rd(8'h60, v);
        chk("R4 status on match", 64'(v[ch]), 64'd1);
        chk("R5 irq on match", 64'(irq[ch]), 64'd1);
        idle(extra);
        rd(na, v);
        chk("R4 R2 counts past match", 64'(v), 64'(m) + ticks(extra, p));
        wr(ca, ctrl_word(p, 3'b000));
        chk("R5 irq off when disabled", 64'(irq[ch]), 64'd0);
        rd(8'h60, v);
        chk("R5 status kept when disabled", 64'(v[ch]), 64'd1);
    endtask

    initial begin
        int unsigned c;
        c = 0;
        while (!done && c < 150000) begin
            @(posedge clk);
            c++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        void'($urandom(32'd20251));
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        for (int a = 0; a <= 8'h80; a += 4) begin
            rd(8'(a), v);
            chk("R1 reset register zero", 64'(v), 64'd0);
        end
        chk("R1 irq low after reset", 64'(irq), 64'd0);
        idle(10);
        rd(8'h6C, v);
        chk("R1 R7 wide halted before load", 64'(v), 64'd0);

        // R3 readback of storage registers
        wr(8'h64, 32'hA5C3_0F01);
        rd(8'h64, v);
        chk("R3 watchdog storage", 64'(v), 64'hA5C3_0F01);
        wr(8'h1C, 32'h1234_5678);
        rd(8'h1C, v);
        chk("R3 match1 readback", 64'(v), 64'h1234_5678);
        wr(8'h74, 32'hDEAD_BEEF);
        rd(8'h74, v);
        chk("R3 load low readback", 64'(v), 64'hDEAD_BEEF);
        rd(8'h6C, v);
        chk("R7 load regs alone do not start", 64'(v), 64'd0);

        // R2 partial enable holds count
        wr(8'h48, 32'd7);
        wr(8'h00, ctrl_word(0, 3'b011));
        idle(5);
        rd(8'h48, v);
        chk("R2 partial enable holds", 64'(v), 64'd7);
        wr(8'h00, ctrl_word(2, 3'b111));
        idle(9);
        rd(8'h48, v);
        chk("R2 prescaled count", 64'(v), 64'd7 + ticks(9, 2));
        rd(8'h00, v);
        chk("R3 control readback", 64'(v), 64'(ctrl_word(2, 3'b111)));
        wr(8'h00, 32'd0);
        idle(4);
        rd(8'h48, v2);
        chk("R2 disabled holds", 64'(v2), 64'd7 + ticks(10, 2));

        // R4 R5 random arming on both channels
        for (int k = 0; k < 8; k++) begin
            arm_test(int'($urandom_range(1, 0)), $urandom_range(3, 0),
                     $urandom_range(12, 1), $urandom_range(9, 0));
        end

        // R6 selective and total clear
        wr(8'h48, 0); wr(8'h4C, 0);
        wr(8'h18, 2); wr(8'h1C, 3);
        wr(8'h00, ctrl_word(0, 3'b111));
        wr(8'h04, ctrl_word(0, 3'b111));
        idle(4);
        rd(8'h60, v);
        chk("R6 both pending", 64'(v), 64'd3);
        wr(8'h00, 0); wr(8'h04, 0);
        wr(8'h60, 32'h1);
        rd(8'h60, v);
        chk("R6 clear bit0 only", 64'(v), 64'd2);
        wr(8'h60, 32'h0);
        rd(8'h60, v);
        chk("R6 zero write no effect", 64'(v), 64'd2);
        wr(8'h60, 32'hFFFF);
        rd(8'h60, v);
        chk("R6 clear all", 64'(v), 64'd0);

        // R8 carry coherence, R7 load, R9 prescale, R11 wrap
        snap_test("R8 R7 snapshot before carry", 64'h0000_0001_FFFF_FFFF, 0, 0);
        snap_test("R8 snapshot after carry",     64'h0000_0001_FFFF_FFFF, 0, 1);
        snap_test("R8 snapshot across carry",    64'h0000_0004_FFFF_FFFD, 0, 5);
        snap_test("R11 wrap to zero",            64'hFFFF_FFFF_FFFF_FFFF, 0, 3);
        snap_test("R9 wide prescale",            64'h0000_0000_0000_0100, 2, 10);
        for (int k = 0; k < 6; k++) begin
            logic [63:0] x;
            x = {32'($urandom), 32'hFFFF_FFF0 | 32'($urandom_range(15, 0))};
            snap_test("R8 R9 random snapshot", x, $urandom_range(3, 0), $urandom_range(40, 0));
        end

        // R10 command bits read zero
        wr(8'h68, ctrl_word(16'h2A, 3'b001));
        rd(8'h68, v);
        chk("R10 command bits read zero", 64'(v), 64'(ctrl_word(16'h2A, 3'b000)));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule